// File: doc/BRIEF.md
# Periodic Converter Trigger and Serial Result Reader

This block sits on the host side of a serial analog-to-digital converter. An internal timer fires once every programmed number of system clocks. Each firing sends a one-cycle convert-start pulse to the converter. The block then watches the converter's busy flag. When that flag drops, the block reads the finished sample over an SPI link, acting as the clock master.

The read is a single chip-select window that carries three back-to-back bytes, 24 serial clocks in all. The serial clock idles low. The converter changes its data on each rising edge, and the block captures the bit on the following falling edge. Bits arrive most significant first. The first 18 captured bits form the sample, and the last 6 are thrown away.

When the read finishes, the sample appears on a data bus qualified by a one-cycle valid strobe. A timer firing that lands while an acquisition is still running is discarded and reported on a one-cycle drop strobe.

Top module: `cnv_readout_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `spi_cs_n` is 1 and `spi_sclk`, `cnv_start`, `res_valid` and `trig_drop` are all 0.
- R2: With a nonzero `period_cfg` of P held steady, timer events occur exactly every P clock cycles. Each event shows up one cycle later as either a `cnv_start` pulse or a `trig_drop` pulse, never both.
- R3: With `period_cfg` equal to 0, the timer is stopped and neither `cnv_start` nor `trig_drop` is raised.
- R4: `spi_cs_n` falls only after `busy_in` has dropped following a convert-start. A fall of `busy_in` while no conversion is pending is ignored, and `spi_cs_n` stays high.
- R5: `spi_cs_n` stays low for the whole read, during which exactly 24 rising edges of `spi_sclk` occur. `spi_sclk` is low whenever `spi_cs_n` is high.
- R6: Each phase of `spi_sclk` lasts HALF_DIV system clocks, so the rising-to-rising interval is 2*HALF_DIV clocks. That interval must be at least ceil(CLK_HZ / 17,000,000) clocks, which keeps the link at 17 Mbit/s or below.
- R7: `spi_miso` is sampled at each falling edge of `spi_sclk`. The first captured bit is `res_data[17]` and the 18th is `res_data[0]`. Captured bits 19 to 24 have no effect on `res_data`.
- R8: `res_valid` is high for exactly one cycle per read. It rises in the same cycle that `spi_cs_n` returns high, and `res_data` is valid in that cycle.
- R9: A timer event in any cycle from the `cnv_start` cycle through the `res_valid` cycle of the same acquisition, both ends included, gives a one-cycle `trig_drop` pulse and no `cnv_start`.
- R10: A timer event in the cycle right after a `res_valid` cycle is accepted and produces `cnv_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_cfg | input | PER_W | Timer period in clocks; 0 stops the timer |
| cnv_start | output | 1 | One-cycle convert-start pulse to the converter |
| busy_in | input | 1 | Converter busy flag (asynchronous) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle strobe marking a new sample |
| res_data | output | 18 | Assembled sample |
| trig_drop | output | 1 | One-cycle strobe for a discarded timer event |

## Verification
The timer event and the final result strobe can land in the same cycle. The bench first measures the cycle count from `cnv_start` to `res_valid` for its converter model. It then sets the period to that count plus one, so that a timer event coincides with `res_valid`. After that it sets the period to the count plus two, so that the event falls one cycle later.

Every `cnv_start` or `trig_drop` pulse is judged against a window the bench tracks from the ports alone: the window opens at `cnv_start` and closes after `res_valid`. The bench also confirms that both the coincident case and the back-to-back case actually occurred.

// File: rtl/cnvrd_pkg.sv
package cnvrd_pkg;

    localparam int RES_BITS  = 18;
    localparam int BYTE_BITS = 8;
    localparam int NUM_BYTES = 3;
    localparam int XFER_BITS = BYTE_BITS * NUM_BYTES;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CONV = 2'd1,
        SEQ_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic                valid;
        logic [RES_BITS-1:0] data;
    } result_t;

    // smallest rising-to-rising gap in system clocks that keeps the bit rate legal
    function automatic int min_sclk_cycles(input int clk_hz, input int max_bps);
        return (clk_hz + max_bps - 1) / max_bps;
    endfunction

endpackage

// File: rtl/cnvrd_timer.sv
module cnvrd_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (period == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= period - PER_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + PER_W'(1);
            tick <= 1'b0;
        end
    end

    assert_timer_off_R3: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |=> !tick);

endmodule

// File: rtl/cnvrd_busy_sync.sv
module cnvrd_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_in,
    output logic busy_fall
);
    logic busy_s;
    logic busy_prev;

    generate
        if (STAGES == 0) begin : g_bypass
            assign busy_s = busy_in;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= busy_in;
            end
            for (genvar i = 1; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
            assign busy_s = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) busy_prev <= 1'b0;
        else     busy_prev <= busy_s;
    end

    assign busy_fall = busy_prev & ~busy_s;

endmodule

// File: rtl/cnvrd_spi_rx.sv
module cnvrd_spi_rx
    import cnvrd_pkg::*;
#(
    parameter int HALF_DIV = 6,
    parameter int CLK_HZ   = 200_000_000,
    parameter int MAX_BPS  = 17_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                miso,
    output logic                sclk,
    output logic                cs_n,
    output logic                done,
    output logic [RES_BITS-1:0] word
);
    localparam int HC_W    = $clog2(HALF_DIV + 1);
    localparam int BC_W    = $clog2(XFER_BITS);
    localparam int MIN_CYC = min_sclk_cycles(CLK_HZ, MAX_BPS);

    logic                active;
    logic [HC_W-1:0]     hcnt;
    logic [BC_W-1:0]     bcnt;
    logic [RES_BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sclk   <= 1'b0;
            hcnt   <= '0;
            bcnt   <= '0;
            shreg  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    sclk   <= 1'b0;
                    hcnt   <= '0;
                    bcnt   <= '0;
                end
            end else if (hcnt == HC_W'(HALF_DIV - 1)) begin
                hcnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bcnt < BC_W'(RES_BITS))
                        shreg <= {shreg[RES_BITS-2:0], miso};
                    bcnt <= bcnt + BC_W'(1);
                    if (bcnt == BC_W'(XFER_BITS - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + HC_W'(1);
            end
        end
    end

    assign cs_n = ~active;
    assign word = shreg;

    // rate checker: clocks between successive rising edges of sclk
    logic        sclk_d;
    logic        seen_rise;
    logic [15:0] gap;
    logic        rise;

    assign rise = sclk & ~sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            seen_rise <= 1'b0;
            gap       <= '0;
        end else begin
            sclk_d <= sclk;
            if (rise) begin
                seen_rise <= 1'b1;
                gap       <= 16'd1;
            end else if (gap != 16'hFFFF) begin
                gap <= gap + 16'd1;
            end
        end
    end

    assert_sclk_rate_R6: assert property (@(posedge clk) disable iff (rst)
        (rise && seen_rise) |-> (gap >= 16'(MIN_CYC)));

    assert_sclk_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

endmodule

// File: rtl/cnv_readout_ctrl.sv
module cnv_readout_ctrl
    import cnvrd_pkg::*;
#(
    parameter int CLK_HZ       = 200_000_000,
    parameter int MAX_SCLK_BPS = 17_000_000,
    parameter int HALF_DIV     = 6,
    parameter int PER_W        = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PER_W-1:0]    period_cfg,
    output logic                cnv_start,
    input  logic                busy_in,
    output logic                spi_sclk,
    output logic                spi_cs_n,
    input  logic                spi_miso,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic                trig_drop
);
    seq_state_e          st;
    logic                tick;
    logic                busy_fall;
    logic                xfer_go;
    logic                rx_done;
    logic [RES_BITS-1:0] rx_word;
    result_t             res;

    cnvrd_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .period (period_cfg),
        .tick   (tick)
    );

    cnvrd_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .busy_in   (busy_in),
        .busy_fall (busy_fall)
    );

    cnvrd_spi_rx #(
        .HALF_DIV (HALF_DIV),
        .CLK_HZ   (CLK_HZ),
        .MAX_BPS  (MAX_SCLK_BPS)
    ) u_rx (
        .clk  (clk),
        .rst  (rst),
        .go   (xfer_go),
        .miso (spi_miso),
        .sclk (spi_sclk),
        .cs_n (spi_cs_n),
        .done (rx_done),
        .word (rx_word)
    );

    assign xfer_go = (st == SEQ_CONV) && busy_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEQ_IDLE;
            cnv_start <= 1'b0;
            trig_drop <= 1'b0;
        end else begin
            cnv_start <= 1'b0;
            trig_drop <= tick && (st != SEQ_IDLE);
            case (st)
                SEQ_IDLE: if (tick) begin
                    cnv_start <= 1'b1;
                    st        <= SEQ_CONV;
                end
                SEQ_CONV: if (busy_fall) st <= SEQ_XFER;
                SEQ_XFER: if (rx_done)   st <= SEQ_IDLE;
                default:  st <= SEQ_IDLE;
            endcase
        end
    end

    assign res.valid = rx_done;
    assign res.data  = rx_word;
    assign res_valid = res.valid;
    assign res_data  = res.data;

    assert_read_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> $past(busy_fall));

    assert_one_event_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cnv_start, trig_drop}));

    assert_drop_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        trig_drop |-> ($past(st) != SEQ_IDLE));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_valid_cs_high_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> spi_cs_n);

endmodule

// File: tb/sim_cnv_readout_ctrl.sv
`timescale 1ns/1ps
module sim_cnv_readout_ctrl;
    localparam int HALF_DIV = 6;
    localparam int PER_W    = 16;
    localparam int BUSY_LEN = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PER_W-1:0] period_cfg = '0;
    logic             busy_m = 1'b0;
    logic             stray = 1'b0;
    logic             miso = 1'b0;
    logic             cnv_start, spi_sclk, spi_cs_n, res_valid, trig_drop;
    logic [17:0]      res_data;

    always #2.5 clk = ~clk;

    cnv_readout_ctrl #(.HALF_DIV(HALF_DIV), .PER_W(PER_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .period_cfg (period_cfg),
        .cnv_start  (cnv_start),
        .busy_in    (busy_m | stray),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_miso   (miso),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .trig_drop  (trig_drop)
    );

    int errs = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard
    logic [17:0] exp_q[$];
    logic [17:0] cur_sample = 18'h3FFFF;
    logic [23:0] slave_word = '0;
    int          busy_cnt = 0;

    // monitor state
    longint cyc = 0;
    int     bit_idx = 0, rises = 0;
    longint last_rise = -1;
    bit     sclk_prev = 0, cs_prev = 1;
    bit     inwin = 0, vd1 = 0, vd2 = 0;
    longint s_cyc = 0, last_len = 0;
    longint last_ev = 0;
    bit     have_ev = 0;
    bit     per_chg = 0;
    int     off_cyc = 0, off_evs = 0;
    int     hits_coinc = 0, hits_b2b = 0, results = 0;

    always @(negedge clk) begin
        bit ev, exp_drop, nw;
        string tag;
        cyc++;
        if (!rst) begin
            // converter model: busy after start, result pushed when busy drops
            if (cnv_start) begin
                busy_m   = 1'b1;
                busy_cnt = BUSY_LEN;
            end else if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    busy_m = 1'b0;
                    exp_q.push_back(cur_sample);
                    slave_word = {cur_sample, 6'b101101};
                    if (cur_sample == 18'h3FFFF) cur_sample = 18'h00000;
                    else if (cur_sample == 18'h00000) cur_sample = 18'h2A5C3;
                    else cur_sample = {cur_sample[16:0], cur_sample[17] ^ cur_sample[10]} ^ 18'h0155A;
                end
            end

            // serial slave and link checks
            if (!spi_cs_n && cs_prev) begin
                chk(busy_m == 1'b0, "R4 cs_n fell while busy high", busy_m, 0);
                rises = 0; bit_idx = 0; last_rise = -1;
            end
            if (spi_cs_n && spi_sclk)
                chk(0, "R5 sclk high while deselected", spi_sclk, 0);
            if (!spi_cs_n && spi_sclk && !sclk_prev) begin
                if (last_rise >= 0)
                    chk(cyc - last_rise == 2*HALF_DIV, "R6 sclk period", cyc - last_rise, 2*HALF_DIV);
                last_rise = cyc;
                miso = (bit_idx < 24) ? slave_word[23 - bit_idx] : 1'b0;
                bit_idx++;
                rises++;
            end
            if (spi_cs_n && !cs_prev)
                chk(rises == 24, "R5 rising edges per read", rises, 24);

            // result scoreboard
            if (res_valid) begin
                chk(spi_cs_n == 1'b1, "R8 cs_n high at valid", spi_cs_n, 1);
                chk(exp_q.size() > 0, "R7 result without conversion", exp_q.size(), 1);
                if (exp_q.size() > 0) begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    chk(res_data == e, "R7 sample value", res_data, e);
                end
                last_len = cyc - s_cyc;
                results++;
            end
            if (vd1 && res_valid) chk(0, "R8 valid longer than one cycle", 1, 0);

            // trigger events
            ev = cnv_start | trig_drop;
            if (per_chg) begin
                have_ev = 0; off_cyc = 0; per_chg = 0;
            end
            if (period_cfg == '0) begin
                off_cyc++;
                if (off_cyc > 2 && ev) off_evs++;
            end
            if (ev) begin
                chk(!(cnv_start && trig_drop), "R2 both strobes", 1, 0);
                exp_drop = inwin;
                tag = vd2 ? "R10 start after valid" : (exp_drop ? "R9 drop in window" : "R2 start when idle");
                chk(trig_drop == exp_drop, tag, trig_drop, exp_drop);
                if (vd1) hits_coinc++;
                if (vd2 && !exp_drop) hits_b2b++;
                if (have_ev && period_cfg != '0)
                    chk(cyc - last_ev == longint'(period_cfg), "R2 event interval", cyc - last_ev, period_cfg);
                last_ev = cyc; have_ev = 1;
            end
            if (cnv_start) s_cyc = cyc;
            nw = cnv_start || (inwin && !vd1);
            inwin = nw;
        end
        vd2 = vd1;
        vd1 = res_valid;
        sclk_prev = spi_sclk;
        cs_prev = spi_cs_n;
    end

    task automatic set_period(input int p);
        @(negedge clk); #1;
        period_cfg = PER_W'(p);
        per_chg = 1;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1 && spi_sclk == 0, "R1 link idle in reset", {spi_cs_n, spi_sclk}, 2'b10);
        chk(cnv_start == 0 && res_valid == 0 && trig_drop == 0, "R1 strobes low in reset",
            {cnv_start, res_valid, trig_drop}, 0);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1 && spi_sclk == 0 && cnv_start == 0 && res_valid == 0 && trig_drop == 0,
            "R1 after release", {spi_cs_n, spi_sclk, cnv_start, res_valid, trig_drop}, 5'b10000);

        // timer stopped
        wait_cycles(60);
        // stray busy fall with nothing pending
        @(negedge clk); #1 stray = 1'b1;
        wait_cycles(6);
        @(negedge clk); #1 stray = 1'b0;
        begin
            bit stayed = 1;
            repeat (30) begin
                @(negedge clk);
                if (!spi_cs_n) stayed = 0;
            end
            chk(stayed, "R4 stray busy fall ignored", !stayed, 0);
        end
        chk(off_evs == 0, "R3 no events while period is zero", off_evs, 0);

        // relaxed period, measures acquisition length
        set_period(500);
        wait_cycles(2100);
        begin
            int len;
            len = int'(last_len);
            chk(len > 2*HALF_DIV*24, "R5 acquisition length", len, 2*HALF_DIV*24);
            set_period(len + 1);   // event lands on the valid cycle
            wait_cycles((len + 1) * 8);
            set_period(len + 2);   // event lands the cycle after valid
            wait_cycles((len + 2) * 5);
            set_period(len);
            wait_cycles(len * 5);
        end
        set_period(37);
        wait_cycles(1500);
        set_period(0);
        wait_cycles(800);
        chk(off_evs == 0, "R3 timer stopped after run", off_evs, 0);
        chk(exp_q.size() == 0, "R7 every conversion read", exp_q.size(), 0);
        chk(hits_coinc > 0, "R9 coincident event seen", hits_coinc, 1);
        chk(hits_b2b > 0, "R10 back-to-back event seen", hits_b2b, 1);
        chk(results >= 15, "R8 result count", results, 15);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule